// File: doc/BRIEF.md
# I2C Target Controller with 7-bit and 10-bit Addressing

This block is the target (slave) side of an I2C port, clocked by the system clock. It oversamples the SCL and SDA bus lines through synchronizer flops and finds START, repeated START and STOP conditions on the synchronized levels. It then compares the incoming address against a programmable 10-bit address. A mode input selects 7-bit or 10-bit matching. The block acknowledges matched addresses and accepted data bytes. It moves each received byte from its shift register into a separate holding buffer. For reads, it sends bytes straight out of a single transmit register.

Both bus lines are open-drain. The block only outputs pull-down enables, and the surrounding pad logic wires them onto the bus. Before each byte it sends, the block holds SCL low and raises a transmit interrupt pulse. Software then loads the transmit register and strobes a release input, and only after that strobe does the block let the clock go. A receive interrupt pulse marks each byte that lands in the holding buffer. Software empties the buffer with a pop strobe.

Top module: `i2c_addr10_target`

## Requirements
- R1: With `ten_bit_mode`=0, an address byte whose bits 7..1 equal `own_addr[6:0]` is acknowledged: SDA is pulled low for the ninth SCL clock. Any other address byte is not acknowledged. Until the next START, the data bytes that follow are then ignored: they cause no acknowledge, no `irq_rx` pulse and no change of `rx_full`.
- R2: With `ten_bit_mode`=1, the block acknowledges a first byte of the form 11110, `own_addr[9:8]`, R/W=0. It then acknowledges a second byte only if that byte equals `own_addr[7:0]`, and data bytes written after that are accepted. A byte shaped like a 7-bit address is not acknowledged in this mode.
- R3: A data byte can complete while `rx_full` is 1 and `rx_pop` is not asserted. In that case the byte is not acknowledged, `rx_data` keeps its old value and `rx_ovf` is set. A `rx_pop` strobe clears both `rx_full` and `rx_ovf`.
- R4: Each accepted data byte arrives MSB first and appears on `rx_data`. The same clock edge sets `rx_full` and raises `irq_rx` for exactly one cycle.
- R5: Before each transmitted byte, including the first byte after a read address, the block pulls SCL low and pulses `irq_tx`. It keeps SCL low until `scl_rel` is strobed. It then sends `tx_reg` MSB first, where `tx_reg` holds the byte last written through `tx_wr`/`tx_wdata`.
- R6: When the master acknowledges a transmitted byte, the block stretches again as in R5. When the master does not acknowledge a byte, the block releases SDA and does not stretch again.
- R7: With `ten_bit_mode`=1, a first byte 11110, `own_addr[9:8]`, R/W=1 is acknowledged only after a repeated START. The full two-byte match must have come earlier, with no STOP in between. Without such a match, or after a STOP, this byte is not acknowledged.
- R8: A START resets address reception, even in the middle of a transfer. A STOP returns the block to idle with both pull-downs released. The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 10 | Target address |
| ten_bit_mode | input | 1 | 1 selects 10-bit address matching |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | 8 | Byte written into the transmit register |
| scl_rel | input | 1 | Strobe that ends a clock stretch |
| rx_pop | input | 1 | Strobe that empties the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | A byte was refused because the buffer was full |
| irq_rx | output | 1 | One-cycle pulse when a byte enters the receive buffer |
| irq_tx | output | 1 | One-cycle pulse when a stretch starts, asking for the next byte |

## Verification
The hardest state to reach is the 10-bit read. A write header and a matching low byte must come first. The repeated START must then arrive without a STOP, and only after all that does the read header get acknowledged. The bench drives this through a wired-AND bus model and a master model that honours clock stretching. A concurrent responder process answers each `irq_tx` pulse late, so the stretch is long enough to observe. The bench then repeats the read header after a STOP and expects it to be refused. Overflow is reached by writing two bytes without popping the buffer.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int ADDR_W = 10;
   localparam int BYTE_W = 8;
   localparam logic [4:0] HDR10_PREFIX = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADR1,
      ST_ADR2,
      ST_RECV,
      ST_HOLD,
      ST_SEND
   } tgt_st_t;
endpackage

// File: rtl/i2ct_line_sync.sv
// Bus line synchronizer and bus condition detector.
module i2ct_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2ct_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_s, scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_s;
         sda_d    <= sda_s;
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   // R8: conditions are SDA edges while SCL stays high
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2ct_addr_cmp.sv
// Address comparators for both addressing modes.
module i2ct_addr_cmp
   import i2ct_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              hit7,
   output logic              hdr_hit,
   output logic              low_hit
);
   // R1: seven address bits sit above the R/W bit
   assign hit7    = (byte_in[7:1] == own_addr[6:0]);
   // R2/R7: header prefix plus the two upper address bits
   assign hdr_hit = (byte_in[7:3] == HDR10_PREFIX) && (byte_in[2:1] == own_addr[9:8]);
   assign low_hit = (byte_in == own_addr[7:0]);
endmodule

// File: rtl/i2ct_rx_hold.sv
// Receive holding buffer behind the shift register.
module i2ct_rx_hold
   import i2ct_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              pop,
   output logic              accept,
   output logic [BYTE_W-1:0] buf_q,
   output logic              full,
   output logic              ovf,
   output logic              irq
);
   assign accept = ~full | pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         full  <= 1'b0;
         ovf   <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (pop) begin
            full <= 1'b0;
            ovf  <= 1'b0;
         end
         if (byte_done && accept) begin   // R4
            buf_q <= byte_in;
            full  <= 1'b1;
            irq   <= 1'b1;
         end else if (byte_done) begin    // R3: refuse, keep old byte
            ovf <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_addr10_target.sv
module i2c_addr10_target
   import i2ct_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ten_bit_mode,
   input  logic              tx_wr,
   input  logic [BYTE_W-1:0] tx_wdata,
   input  logic              scl_rel,
   input  logic              rx_pop,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovf,
   output logic              irq_rx,
   output logic              irq_tx
);
   localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
   localparam logic [3:0] ACK_DONE = 4'(BYTE_W + 1);

   logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic hit7, hdr_hit, low_hit;
   logic rx_accept, rx_done;

   tgt_st_t st, after_st, dec_next;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg, tx_reg;
   logic              armed, mack, sda_q, scl_q, irq_tx_q;
   logic              dec_ack, arm_set, arm_clr;
   logic [2:0]        tx_idx;

   i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   i2ct_addr_cmp u_cmp (
      .byte_in(shreg), .own_addr(own_addr),
      .hit7(hit7), .hdr_hit(hdr_hit), .low_hit(low_hit)
   );

   assign rx_done = scl_fall && (bitcnt == ACK_SLOT) && (st == ST_RECV) && !start_ev && !stop_ev;

   i2ct_rx_hold u_rx (
      .clk(clk), .rst_n(rst_n), .byte_done(rx_done), .byte_in(shreg), .pop(rx_pop),
      .accept(rx_accept), .buf_q(rx_data), .full(rx_full), .ovf(rx_ovf), .irq(irq_rx)
   );

   // Single transmit register, shifted out in place (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_reg <= '0;
      else if (tx_wr) tx_reg <= tx_wdata;
   end

   assign tx_idx = 3'(4'd7 - bitcnt);

   // Acknowledge decision taken after the eighth bit of a byte
   always_comb begin
      dec_ack  = 1'b0;
      dec_next = ST_IDLE;
      arm_set  = 1'b0;
      arm_clr  = 1'b0;
      case (st)
         ST_ADR1: begin
            if (!ten_bit_mode) begin                     // R1
               if (hit7) begin
                  dec_ack  = 1'b1;
                  dec_next = shreg[0] ? ST_HOLD : ST_RECV;
               end
            end else if (hdr_hit && !shreg[0]) begin     // R2
               dec_ack  = 1'b1;
               dec_next = ST_ADR2;
               arm_clr  = 1'b1;
            end else if (hdr_hit && armed) begin         // R7
               dec_ack  = 1'b1;
               dec_next = ST_HOLD;
            end else begin
               arm_clr = 1'b1;
            end
         end
         ST_ADR2: begin
            if (low_hit) begin
               dec_ack  = 1'b1;
               dec_next = ST_RECV;
               arm_set  = 1'b1;
            end else begin
               arm_clr = 1'b1;
            end
         end
         ST_RECV: begin
            if (rx_accept) begin                         // R3
               dec_ack  = 1'b1;
               dec_next = ST_RECV;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         after_st <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         armed    <= 1'b0;
         mack     <= 1'b0;
         sda_q    <= 1'b0;
         scl_q    <= 1'b0;
         irq_tx_q <= 1'b0;
      end else begin
         irq_tx_q <= 1'b0;
         if (start_ev) begin                             // R8
            st     <= ST_ADR1;
            bitcnt <= '0;
            sda_q  <= 1'b0;
            scl_q  <= 1'b0;
         end else if (stop_ev) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sda_q  <= 1'b0;
            scl_q  <= 1'b0;
            armed  <= 1'b0;
         end else if (st == ST_HOLD) begin
            if (scl_rel) begin                           // R5: drive MSB, free SCL next cycle
               sda_q  <= ~tx_reg[7];
               st     <= ST_SEND;
               bitcnt <= '0;
            end
         end else if (st != ST_IDLE) begin
            if (st == ST_SEND && scl_q) begin
               scl_q <= 1'b0;
            end
            if (scl_rise) begin
               if (bitcnt < ACK_SLOT) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (bitcnt == ACK_SLOT) begin
                  bitcnt <= ACK_DONE;
                  mack   <= ~sda_s;
               end
            end
            if (scl_fall) begin
               if (bitcnt == ACK_SLOT) begin
                  if (st == ST_SEND) begin
                     sda_q <= 1'b0;
                  end else begin
                     sda_q    <= dec_ack;
                     after_st <= dec_next;
                     if (arm_set)      armed <= 1'b1;
                     else if (arm_clr) armed <= 1'b0;
                  end
               end else if (bitcnt == ACK_DONE) begin
                  sda_q  <= 1'b0;
                  bitcnt <= '0;
                  if ((st == ST_SEND) ? mack : (after_st == ST_HOLD)) begin  // R6
                     st       <= ST_HOLD;
                     scl_q    <= 1'b1;
                     irq_tx_q <= 1'b1;
                  end else begin
                     st <= (st == ST_SEND) ? ST_IDLE : after_st;
                  end
               end else if (st == ST_SEND && bitcnt != 4'd0) begin
                  sda_q <= ~tx_reg[tx_idx];
               end
            end
         end
      end
   end

   assign sda_oe = sda_q;
   assign scl_oe = scl_q;
   assign irq_tx = irq_tx_q;
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       scl_rel,
   input logic       rx_pop,
   input logic       irq_rx,
   input logic       irq_tx,
   input logic       rx_full,
   input logic       rx_ovf,
   input logic [7:0] rx_data
);
   p_irq_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |=> !irq_rx);
   p_irq_rx_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> rx_full);
   p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_pop) |=> (rx_full && $stable(rx_data)));
   p_ovf_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> !sda_oe);
   p_hold_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> irq_tx);
   p_release_by_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |-> $past(scl_rel, 2));
   p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind i2c_addr10_target i2ct_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .scl_rel(scl_rel), .rx_pop(rx_pop), .irq_rx(irq_rx), .irq_tx(irq_tx),
   .rx_full(rx_full), .rx_ovf(rx_ovf), .rx_data(rx_data)
);

// File: tb/sim_i2c_addr10_target.sv
module sim_i2c_addr10_target;
   localparam int Q = 10;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, m_scl_lo, m_sda_lo;
   logic scl_oe, sda_oe, ten_bit_mode, tx_wr, scl_rel, rx_pop;
   logic rx_full, rx_ovf, irq_rx, irq_tx;
   logic [9:0] own_addr;
   logic [7:0] tx_wdata, rx_data;
   logic scl_bus, sda_bus;

   assign scl_bus = ~(m_scl_lo | scl_oe);
   assign sda_bus = ~(m_sda_lo | sda_oe);

   i2c_addr10_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .scl_rel(scl_rel), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   int errs = 0, checks = 0, irq_rx_cnt = 0, hold_cnt = 0, tx_idx = 0;
   logic [7:0] tx_q [0:7];

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_lo = 1'b0; tick(Q);
      m_scl_lo = 1'b0; wait_scl_high(); tick(Q);
      m_sda_lo = 1'b1; tick(Q);
      m_scl_lo = 1'b1; tick(Q);
   endtask

   task automatic m_stop();
      m_sda_lo = 1'b1; tick(Q);
      m_scl_lo = 1'b0; wait_scl_high(); tick(Q);
      m_sda_lo = 1'b0; tick(Q);
   endtask

   task automatic m_bit(input bit b, output bit s);
      m_sda_lo = ~b; tick(Q);
      m_scl_lo = 1'b0; wait_scl_high(); tick(Q/2);
      s = sda_bus; tick(Q/2);
      m_scl_lo = 1'b1; tick(2);
   endtask

   task automatic m_wbyte(input logic [7:0] d, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) m_bit(d[i], s);
      m_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic m_rbyte(output logic [7:0] d, input bit ack);
      bit s;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         m_bit(1'b1, s);
         d = {d[6:0], s};
      end
      m_bit(~ack, s);
   endtask

   task automatic pop();
      rx_pop = 1'b1; tick(1); rx_pop = 1'b0; tick(1);
   endtask

   function automatic logic [7:0] hdr10(logic [9:0] a, bit rw);
      return {5'b11110, a[9:8], rw};
   endfunction

   function automatic bit exp_hit7(logic [7:0] b, logic [9:0] a);
      return b[7:1] == a[6:0];
   endfunction

   // Software responder: answers each stretch late, then releases SCL
   initial begin
      tx_wr = 0; scl_rel = 0; tx_wdata = '0;
      forever begin
         @(negedge clk);
         if (irq_tx) begin
            hold_cnt++;
            tick(25);
            check("R5 clock held until release", scl_oe, 1);
            tx_wdata = tx_q[tx_idx];
            tx_idx++;
            tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
            scl_rel = 1'b1; tick(1); scl_rel = 1'b0;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (irq_rx) irq_rx_cnt++;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] d, d1, r;
      int c0, h0;
      void'($urandom(32'd4242));
      rst_n = 0; m_scl_lo = 0; m_sda_lo = 0; rx_pop = 0;
      ten_bit_mode = 0; own_addr = 10'h05A;
      tick(5);
      check("reset scl_oe", scl_oe, 0);
      check("reset sda_oe", sda_oe, 0);
      check("reset rx_full", rx_full, 0);
      check("reset rx_ovf", rx_ovf, 0);
      rst_n = 1; tick(5);

      // R1 + R4: matched 7-bit write
      m_start();
      m_wbyte({7'h5A, 1'b0}, ack); check("R1 addr ack", ack, 1);
      for (int k = 0; k < 2; k++) begin
         d = 8'($urandom); c0 = irq_rx_cnt;
         m_wbyte(d, ack);
         check("R4 data ack", ack, 1);
         check("R4 rx_data", rx_data, d);
         check("R4 rx_full", rx_full, 1);
         check("R4 one irq_rx", irq_rx_cnt, c0 + 1);
         pop();
         check("R4 pop empties", rx_full, 0);
      end
      m_stop();

      // R3: overflow
      m_start();
      m_wbyte({7'h5A, 1'b0}, ack);
      d1 = 8'($urandom); m_wbyte(d1, ack);
      d = ~d1; m_wbyte(d, ack);
      check("R3 overflow nack", ack, 0);
      check("R3 ovf flag", rx_ovf, 1);
      check("R3 data kept", rx_data, d1);
      m_stop(); pop();
      check("R3 pop clears full", rx_full, 0);
      check("R3 pop clears ovf", rx_ovf, 0);

      // R1: mismatch ignored
      m_start();
      m_wbyte({7'h5B, 1'b0}, ack); check("R1 mismatch nack", ack, 0);
      c0 = irq_rx_cnt;
      m_wbyte(8'h3C, ack);
      check("R1 ignored data nack", ack, 0);
      check("R1 ignored no irq", irq_rx_cnt, c0);
      check("R1 ignored rx_full", rx_full, 0);
      m_stop();

      // R1: random addresses
      for (int k = 0; k < 8; k++) begin
         logic [7:0] ab;
         bit e;
         ab = {((k % 2 == 0) ? 7'h5A : 7'($urandom)), 1'b0};
         e = exp_hit7(ab, own_addr);
         m_start();
         m_wbyte(ab, ack); check("R1 random addr", ack, e);
         d = 8'($urandom); c0 = irq_rx_cnt;
         m_wbyte(d, ack);
         check("R1 random data ack", ack, e);
         check("R1 random irq", irq_rx_cnt, c0 + (e ? 1 : 0));
         if (e) begin check("R4 random data", rx_data, d); pop(); end
         m_stop();
      end

      // R5 + R6: 7-bit read of three bytes
      for (int k = 0; k < 3; k++) tx_q[k] = 8'($urandom);
      tx_idx = 0; h0 = hold_cnt;
      m_start();
      m_wbyte({7'h5A, 1'b1}, ack); check("R5 read addr ack", ack, 1);
      m_rbyte(r, 1'b1); check("R5 first byte", r, tx_q[0]);
      m_rbyte(r, 1'b1); check("R6 second byte", r, tx_q[1]);
      m_rbyte(r, 1'b0); check("R6 last byte", r, tx_q[2]);
      tick(5);
      check("R6 stretches", hold_cnt, h0 + 3);
      check("R6 sda released", sda_oe, 0);
      m_stop(); tick(60);
      check("R6 no stretch after nack", hold_cnt, h0 + 3);
      check("R6 scl free", scl_oe, 0);

      // R8: repeated START mid-write to foreign address
      m_start();
      m_wbyte({7'h5A, 1'b0}, ack);
      m_wbyte(8'h77, ack); pop();
      m_start();
      m_wbyte({7'h11, 1'b0}, ack); check("R8 restart new addr", ack, 0);
      c0 = irq_rx_cnt;
      m_wbyte(8'h99, ack);
      check("R8 restart ignored", irq_rx_cnt, c0);
      m_stop();
      check("R8 stop releases scl", scl_oe, 0);
      check("R8 stop releases sda", sda_oe, 0);

      // R2: 10-bit write
      ten_bit_mode = 1; own_addr = 10'h2C7;
      m_start();
      m_wbyte(hdr10(own_addr, 1'b0), ack); check("R2 header ack", ack, 1);
      m_wbyte(own_addr[7:0], ack); check("R2 low ack", ack, 1);
      d = 8'($urandom); m_wbyte(d, ack);
      check("R2 data ack", ack, 1); check("R2 data", rx_data, d);
      pop(); m_stop();
      m_start();
      m_wbyte(hdr10(own_addr, 1'b0), ack);
      m_wbyte(own_addr[7:0] ^ 8'h01, ack); check("R2 wrong low nack", ack, 0);
      m_stop();
      m_start();
      m_wbyte({own_addr[6:0], 1'b0}, ack); check("R2 7-bit form refused", ack, 0);
      m_stop();

      // R7: 10-bit read via repeated START
      tx_q[3] = 8'($urandom); tx_idx = 3;
      m_start();
      m_wbyte(hdr10(own_addr, 1'b0), ack);
      m_wbyte(own_addr[7:0], ack);
      m_start();
      m_wbyte(hdr10(own_addr, 1'b1), ack); check("R7 read header ack", ack, 1);
      m_rbyte(r, 1'b0); check("R7 read data", r, tx_q[3]);
      m_stop();
      m_start();
      m_wbyte(hdr10(own_addr, 1'b1), ack); check("R7 header after stop", ack, 0);
      m_stop();

      tick(20);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule